// File: doc/BRIEF.md
# Conditional Integer ALU with Status Flags

This block is the execute-stage arithmetic and logic unit of a three-operand integer pipeline. Each cycle it takes a 4-bit operation code, a set-status bit, a 4-bit condition selector, a first operand and an already-shifted second operand together with the carry that the shifter produced. It returns the 32-bit result and a register write enable at once, without a clock, and keeps a four-bit Negative/Zero/Carry/oVerflow status register that updates on the following clock edge.

The condition selector is tested against the stored status bits before anything happens. When the test fails the instruction leaves no trace: no register write and no status change. Subtraction follows the convention where carry set means no borrow, so the same adder serves every add and subtract form. Comparison operations only touch the status register.

Top module: `dp_alu_unit`

## Requirements
- R1: Operation codes are AND=0, EOR=1, SUB=2, RSB=3, ADD=4, ADC=5, SBC=6, RSC=7, TST=8, TEQ=9, CMP=A, CMN=B, ORR=C, MOV=D, BIC=E, MVN=F. ADD gives A+B, SUB gives A-B and RSB gives B-A, all modulo 2^32.
- R2: ADC gives A+B+C, SBC gives A-B-1+C and RSC gives B-A-1+C, where C is the stored carry flag.
- R3: For arithmetic operations that update status, C takes the carry out of bit 31 of the adder; after a subtraction C=1 means no borrow occurred.
- R4: For arithmetic operations that update status, V is set exactly when the signed result overflowed.
- R5: AND, ORR, EOR and BIC give A&B, A|B, A^B and A&~B; MOV gives B and MVN gives ~B, both independent of A.
- R6: For logical operations that update status, V keeps its value, and C takes the shifter carry when the shift-nonzero input is 1 and keeps its value otherwise.
- R7: When status updates, N becomes bit 31 of the result and Z is 1 exactly when the result is zero.
- R8: Status changes only when the set-status input is 1, except that TST, TEQ, CMP and CMN always update status; those four never assert the write enable.
- R9: Condition selectors are EQ=0 (Z), NE=1 (!Z), CS=2 (C), CC=3 (!C), MI=4 (N), PL=5 (!N), VS=6 (V), VC=7 (!V), HI=8 (C&!Z), LS=9 (!C|Z), GE=A (N==V), LT=B (N!=V), GT=C (!Z&N==V), LE=D (Z|N!=V), AL=E (always), F never. A failed condition suppresses both the write enable and the status update.
- R10: The status register, presented as {N,Z,C,V} on bits 3..0, resets to 0000; with the valid input low there is no write enable and no status change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vld_i | input | 1 | An instruction is presented this cycle |
| opcode_i | input | 4 | Operation code |
| set_st_i | input | 1 | Request a status update |
| cond_i | input | 4 | Condition selector |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Shifted second operand |
| sh_carry_i | input | 1 | Carry out of the shifter |
| sh_nonzero_i | input | 1 | The shift amount was nonzero |
| result_o | output | 32 | Operation result |
| wr_en_o | output | 1 | Write the result to the destination register |
| flags_nxt_o | output | 4 | Status value to be stored at the next edge, {N,Z,C,V} |
| flags_o | output | 4 | Stored status, {N,Z,C,V} |

## Verification
A wrong stored status bit is visible on flags_o one edge after the instruction that set it, and it also corrupts the next instruction that depends on it: a carry-using operation returns a result off by one in the same cycle, and a conditional instruction wrongly asserts or withholds wr_en_o. The bench therefore builds each status pattern through real instructions and then sweeps all sixteen condition selectors, so a bad flag or a bad condition decode shows up on the write enable within one cycle of the sweep.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
        OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
        OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
        OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
    } dp_op_e;

    typedef enum logic [3:0] {
        CC_EQ = 4'h0, CC_NE = 4'h1, CC_CS = 4'h2, CC_CC = 4'h3,
        CC_MI = 4'h4, CC_PL = 4'h5, CC_VS = 4'h6, CC_VC = 4'h7,
        CC_HI = 4'h8, CC_LS = 4'h9, CC_GE = 4'hA, CC_LT = 4'hB,
        CC_GT = 4'hC, CC_LE = 4'hD, CC_AL = 4'hE, CC_NV = 4'hF
    } dp_cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    localparam nzcv_t NZCV_RESET = '{n: 1'b0, z: 1'b0, c: 1'b0, v: 1'b0};

    // Adder-based operations: codes 2..7 plus the two arithmetic compares.
    function automatic logic op_is_arith(dp_op_e op);
        case (op)
            OP_SUB, OP_RSB, OP_ADD, OP_ADC,
            OP_SBC, OP_RSC, OP_CMP, OP_CMN: op_is_arith = 1'b1;
            default:                        op_is_arith = 1'b0;
        endcase
    endfunction

    // Status-only operations sit at codes 8..B.
    function automatic logic op_is_compare(dp_op_e op);
        op_is_compare = (op[3:2] == 2'b10);
    endfunction

    function automatic logic cond_holds(dp_cond_e cc, nzcv_t f);
        case (cc)
            CC_EQ:   cond_holds = f.z;
            CC_NE:   cond_holds = !f.z;
            CC_CS:   cond_holds = f.c;
            CC_CC:   cond_holds = !f.c;
            CC_MI:   cond_holds = f.n;
            CC_PL:   cond_holds = !f.n;
            CC_VS:   cond_holds = f.v;
            CC_VC:   cond_holds = !f.v;
            CC_HI:   cond_holds = f.c && !f.z;
            CC_LS:   cond_holds = !f.c || f.z;
            CC_GE:   cond_holds = (f.n == f.v);
            CC_LT:   cond_holds = (f.n != f.v);
            CC_GT:   cond_holds = !f.z && (f.n == f.v);
            CC_LE:   cond_holds = f.z || (f.n != f.v);
            CC_AL:   cond_holds = 1'b1;
            default: cond_holds = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dp_cond_gate.sv
module dp_cond_gate
    import dp_alu_pkg::*;
(
    input  logic     vld_i,
    input  dp_cond_e cond_i,
    input  nzcv_t    flags_i,
    output logic     pass_o
);
    always_comb begin
        pass_o = vld_i && cond_holds(cond_i, flags_i);
    end
endmodule

// File: rtl/dp_exec_core.sv
module dp_exec_core
    import dp_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  dp_op_e           op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             c_flag_i,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o,
    output logic             ovf_o,
    output logic             arith_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] add_x, add_y, logic_res;
    logic             add_ci;
    logic [WIDTH:0]   add_sum;

    // Operand steering: subtraction is x + ~y + ci, reversed forms swap roles.
    always_comb begin
        add_x  = a_i;
        add_y  = b_i;
        add_ci = 1'b0;
        case (op_i)
            OP_ADC: add_ci = c_flag_i;
            OP_SUB, OP_CMP: begin
                add_y  = ~b_i;
                add_ci = 1'b1;
            end
            OP_SBC: begin
                add_y  = ~b_i;
                add_ci = c_flag_i;
            end
            OP_RSB: begin
                add_x  = b_i;
                add_y  = ~a_i;
                add_ci = 1'b1;
            end
            OP_RSC: begin
                add_x  = b_i;
                add_y  = ~a_i;
                add_ci = c_flag_i;
            end
            default: ;
        endcase
    end

    always_comb begin
        add_sum = {1'b0, add_x} + {1'b0, add_y} + {{WIDTH{1'b0}}, add_ci};
    end

    always_comb begin
        case (op_i)
            OP_AND, OP_TST: logic_res = a_i & b_i;
            OP_EOR, OP_TEQ: logic_res = a_i ^ b_i;
            OP_ORR:         logic_res = a_i | b_i;
            OP_MOV:         logic_res = b_i;
            OP_BIC:         logic_res = a_i & ~b_i;
            OP_MVN:         logic_res = ~b_i;
            default:        logic_res = '0;
        endcase
    end

    always_comb begin
        arith_o  = op_is_arith(op_i);
        result_o = arith_o ? add_sum[MSB:0] : logic_res;
        carry_o  = add_sum[WIDTH];
        ovf_o    = (add_x[MSB] == add_y[MSB]) && (add_sum[MSB] != add_x[MSB]);
    end
endmodule

// File: rtl/dp_flag_reg.sv
module dp_flag_reg
    import dp_alu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  nzcv_t nxt_i,
    output nzcv_t q_o
);
    always_ff @(posedge clk) begin
        if (rst) q_o <= NZCV_RESET;
        else     q_o <= nxt_i;
    end
endmodule

// File: rtl/dp_alu_unit.sv
module dp_alu_unit
    import dp_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vld_i,
    input  logic [3:0]       opcode_i,
    input  logic             set_st_i,
    input  logic [3:0]       cond_i,
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    input  logic             sh_carry_i,
    input  logic             sh_nonzero_i,
    output logic [WIDTH-1:0] result_o,
    output logic             wr_en_o,
    output logic [3:0]       flags_nxt_o,
    output logic [3:0]       flags_o
);
    localparam int MSB = WIDTH - 1;

    dp_op_e   op;
    dp_cond_e cc;
    nzcv_t    flags_q, flags_d;
    logic     pass, is_cmp, do_upd;
    logic     carry, ovf, arith;

    assign op = dp_op_e'(opcode_i);
    assign cc = dp_cond_e'(cond_i);

    dp_cond_gate u_cond (
        .vld_i  (vld_i),
        .cond_i (cc),
        .flags_i(flags_q),
        .pass_o (pass)
    );

    dp_exec_core #(.WIDTH(WIDTH)) u_core (
        .op_i    (op),
        .a_i     (opa_i),
        .b_i     (opb_i),
        .c_flag_i(flags_q.c),
        .result_o(result_o),
        .carry_o (carry),
        .ovf_o   (ovf),
        .arith_o (arith)
    );

    always_comb begin
        is_cmp  = op_is_compare(op);
        do_upd  = pass && (set_st_i || is_cmp);
        wr_en_o = pass && !is_cmp;
        flags_d = flags_q;
        if (do_upd) begin
            flags_d.n = result_o[MSB];
            flags_d.z = (result_o == '0);
            if (arith) begin
                flags_d.c = carry;
                flags_d.v = ovf;
            end else if (sh_nonzero_i) begin
                flags_d.c = sh_carry_i;
            end
        end
    end

    dp_flag_reg u_flags (
        .clk  (clk),
        .rst  (rst),
        .nxt_i(flags_d),
        .q_o  (flags_q)
    );

    assign flags_nxt_o = flags_d;
    assign flags_o     = flags_q;

    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (vld_i && opcode_i[3:2] == 2'b10) |-> !wr_en_o); // R8

    AST_NOS_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!set_st_i && opcode_i[3:2] != 2'b10) |=> $stable(flags_o)); // R8

    AST_COND_FAIL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (vld_i && cond_i == 4'hF) |-> !wr_en_o); // R9

    AST_COND_FAIL_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (vld_i && !pass) |=> $stable(flags_o)); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !vld_i |=> ($stable(flags_o) && !$past(wr_en_o))); // R10

    AST_LOGIC_V_HOLD: assert property (@(posedge clk) disable iff (rst)
        (vld_i && !arith) |=> $stable(flags_o[0])); // R6

    AST_Z_TRACKS_RESULT: assert property (@(posedge clk) disable iff (rst)
        do_upd |=> (flags_o[2] == ($past(result_o) == '0))); // R7

    AST_N_TRACKS_RESULT: assert property (@(posedge clk) disable iff (rst)
        do_upd |=> (flags_o[3] == $past(result_o[MSB]))); // R7
endmodule

// File: tb/tb_dp_alu_unit.sv
module tb_dp_alu_unit;
    localparam real CLK_NS = 4.0;

    logic        clk = 1'b0;
    logic        rst;
    logic        vld_i;
    logic [3:0]  opcode_i;
    logic        set_st_i;
    logic [3:0]  cond_i;
    logic [31:0] opa_i, opb_i;
    logic        sh_carry_i, sh_nonzero_i;
    logic [31:0] result_o;
    logic        wr_en_o;
    logic [3:0]  flags_nxt_o, flags_o;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_NS / 2.0) clk = ~clk;

    dp_alu_unit dut (
        .clk(clk), .rst(rst), .vld_i(vld_i), .opcode_i(opcode_i),
        .set_st_i(set_st_i), .cond_i(cond_i), .opa_i(opa_i), .opb_i(opb_i),
        .sh_carry_i(sh_carry_i), .sh_nonzero_i(sh_nonzero_i),
        .result_o(result_o), .wr_en_o(wr_en_o),
        .flags_nxt_o(flags_nxt_o), .flags_o(flags_o)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Issue one instruction; check combinational outputs, then stored flags.
    task automatic issue(string tag, logic [3:0] op, logic s, logic [3:0] cc,
                         logic [31:0] a, logic [31:0] b, logic shc, logic shnz,
                         logic chk_res, logic [31:0] exp_res,
                         logic exp_wr, logic [3:0] exp_fl);
        @(negedge clk);
        vld_i = 1'b1; opcode_i = op; set_st_i = s; cond_i = cc;
        opa_i = a; opb_i = b; sh_carry_i = shc; sh_nonzero_i = shnz;
        #1;
        if (chk_res) chk({tag, " result"}, result_o, exp_res);
        chk({tag, " wr_en"}, {31'b0, wr_en_o}, {31'b0, exp_wr});
        @(posedge clk);
        #1;
        chk({tag, " flags"}, {28'b0, flags_o}, {28'b0, exp_fl});
        vld_i = 1'b0;
    endtask

    function automatic logic cond_model(logic [3:0] c, logic [3:0] f);
        logic n, z, cy, v;
        {n, z, cy, v} = f;
        case (c)
            4'h0: return z;          4'h1: return !z;
            4'h2: return cy;         4'h3: return !cy;
            4'h4: return n;          4'h5: return !n;
            4'h6: return v;          4'h7: return !v;
            4'h8: return cy & !z;    4'h9: return !cy | z;
            4'hA: return n == v;     4'hB: return n != v;
            4'hC: return !z & (n == v);
            4'hD: return z | (n != v);
            4'hE: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic test_reset();
        @(negedge clk);
        chk("R10 reset flags", {28'b0, flags_o}, 32'h0);
        chk("R10 reset wr_en", {31'b0, wr_en_o}, 32'h0);
    endtask

    task automatic test_arith();
        issue("R1 ADD", 4'h4, 1, 4'hE, 32'd1, 32'd2, 0, 0, 1, 32'd3, 1, 4'b0000);
        issue("R3 ADD carry", 4'h4, 1, 4'hE, 32'hFFFFFFFF, 32'd1, 0, 0, 1, 32'h0, 1, 4'b0110);
        issue("R3 SUB noborrow", 4'h2, 1, 4'hE, 32'd5, 32'd3, 0, 0, 1, 32'd2, 1, 4'b0010);
        issue("R3 SUB borrow", 4'h2, 1, 4'hE, 32'd3, 32'd5, 0, 0, 1, 32'hFFFFFFFE, 1, 4'b1000);
        issue("R1 RSB", 4'h3, 1, 4'hE, 32'd3, 32'd5, 0, 0, 1, 32'd2, 1, 4'b0010);
        issue("R4 ADD ovf", 4'h4, 1, 4'hE, 32'h7FFFFFFF, 32'd1, 0, 0, 1, 32'h80000000, 1, 4'b1001);
        issue("R4 SUB ovf", 4'h2, 1, 4'hE, 32'h80000000, 32'd1, 0, 0, 1, 32'h7FFFFFFF, 1, 4'b0011);
    endtask

    task automatic test_carry_in();
        issue("R3 set C", 4'h2, 1, 4'hE, 32'd5, 32'd3, 0, 0, 1, 32'd2, 1, 4'b0010);
        issue("R2 ADC C1", 4'h5, 0, 4'hE, 32'd10, 32'd20, 0, 0, 1, 32'd31, 1, 4'b0010);
        issue("R2 SBC C1", 4'h6, 0, 4'hE, 32'd10, 32'd3, 0, 0, 1, 32'd7, 1, 4'b0010);
        issue("R2 RSC C1", 4'h7, 0, 4'hE, 32'd3, 32'd10, 0, 0, 1, 32'd7, 1, 4'b0010);
        issue("R3 clr C", 4'h4, 1, 4'hE, 32'd1, 32'd2, 0, 0, 1, 32'd3, 1, 4'b0000);
        issue("R2 ADC C0", 4'h5, 0, 4'hE, 32'd10, 32'd20, 0, 0, 1, 32'd30, 1, 4'b0000);
        issue("R2 SBC C0", 4'h6, 0, 4'hE, 32'd10, 32'd3, 0, 0, 1, 32'd6, 1, 4'b0000);
        issue("R2 RSC C0", 4'h7, 0, 4'hE, 32'd3, 32'd10, 0, 0, 1, 32'd6, 1, 4'b0000);
    endtask

    task automatic test_logic();
        issue("R5 AND", 4'h0, 0, 4'hE, 32'hF0F0F0F0, 32'hFF00FF00, 0, 0, 1, 32'hF000F000, 1, 4'b0000);
        issue("R5 ORR", 4'hC, 0, 4'hE, 32'hF0F0F0F0, 32'hFF00FF00, 0, 0, 1, 32'hFFF0FFF0, 1, 4'b0000);
        issue("R5 EOR", 4'h1, 0, 4'hE, 32'hF0F0F0F0, 32'hFF00FF00, 0, 0, 1, 32'h0FF00FF0, 1, 4'b0000);
        issue("R5 BIC", 4'hE, 0, 4'hE, 32'hF0F0F0F0, 32'hFF00FF00, 0, 0, 1, 32'h00F000F0, 1, 4'b0000);
        issue("R5 MOV", 4'hD, 0, 4'hE, 32'hDEADBEEF, 32'h12345678, 0, 0, 1, 32'h12345678, 1, 4'b0000);
        issue("R5 MVN", 4'hF, 0, 4'hE, 32'hDEADBEEF, 32'h0, 0, 0, 1, 32'hFFFFFFFF, 1, 4'b0000);
    endtask

    task automatic test_logic_flags();
        issue("R4 prep V", 4'h4, 1, 4'hE, 32'h7FFFFFFF, 32'd1, 0, 0, 1, 32'h80000000, 1, 4'b1001);
        issue("R6 ANDS shc", 4'h0, 1, 4'hE, 32'h0, 32'h0, 1, 1, 1, 32'h0, 1, 4'b0111);
        issue("R6 MOVS noshift", 4'hD, 1, 4'hE, 32'h0, 32'h80000000, 0, 0, 1, 32'h80000000, 1, 4'b1011);
        issue("R6 MOVS shift", 4'hD, 1, 4'hE, 32'h0, 32'h1, 0, 1, 1, 32'h1, 1, 4'b0001);
    endtask

    task automatic test_compare();
        issue("R8 CMP eq", 4'hA, 0, 4'hE, 32'd5, 32'd5, 0, 0, 0, 32'h0, 0, 4'b0110);
        issue("R8 CMP lt", 4'hA, 0, 4'hE, 32'd3, 32'd5, 0, 0, 0, 32'h0, 0, 4'b1000);
        issue("R8 CMN", 4'hB, 0, 4'hE, 32'hFFFFFFFF, 32'd1, 0, 0, 0, 32'h0, 0, 4'b0110);
        issue("R8 TEQ", 4'h9, 0, 4'hE, 32'd5, 32'd5, 0, 0, 0, 32'h0, 0, 4'b0110);
        issue("R8 TST", 4'h8, 0, 4'hE, 32'h8, 32'h8, 1, 1, 0, 32'h0, 0, 4'b0010);
        issue("R8 ADD noS", 4'h4, 0, 4'hE, 32'hFFFFFFFF, 32'd1, 0, 0, 1, 32'h0, 1, 4'b0010);
    endtask

    task automatic sweep(string tag, logic [3:0] fl);
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            vld_i = 1'b1; opcode_i = 4'h4; set_st_i = 1'b0; cond_i = c[3:0];
            opa_i = 32'd1; opb_i = 32'd1; sh_carry_i = 1'b0; sh_nonzero_i = 1'b0;
            #1;
            chk($sformatf("R9 %s cond %0h", tag, c), {31'b0, wr_en_o},
                {31'b0, cond_model(c[3:0], fl)});
        end
        vld_i = 1'b0;
    endtask

    task automatic test_conditions();
        issue("R9 st0000", 4'h4, 1, 4'hE, 32'd1, 32'd2, 0, 0, 1, 32'd3, 1, 4'b0000);
        sweep("0000", 4'b0000);
        issue("R9 st0110", 4'h4, 1, 4'hE, 32'hFFFFFFFF, 32'd1, 0, 0, 1, 32'h0, 1, 4'b0110);
        sweep("0110", 4'b0110);
        issue("R9 st1000", 4'h2, 1, 4'hE, 32'd3, 32'd5, 0, 0, 1, 32'hFFFFFFFE, 1, 4'b1000);
        sweep("1000", 4'b1000);
        issue("R9 st1001", 4'h4, 1, 4'hE, 32'h7FFFFFFF, 32'd1, 0, 0, 1, 32'h80000000, 1, 4'b1001);
        sweep("1001", 4'b1001);
        issue("R9 st0011", 4'h2, 1, 4'hE, 32'h80000000, 32'd1, 0, 0, 1, 32'h7FFFFFFF, 1, 4'b0011);
        sweep("0011", 4'b0011);
        issue("R9 st0010", 4'h2, 1, 4'hE, 32'd5, 32'd3, 0, 0, 1, 32'd2, 1, 4'b0010);
        sweep("0010", 4'b0010);
        // Failing condition with S set: no write, flags untouched.
        issue("R9 EQ fail S", 4'h4, 1, 4'h0, 32'hFFFFFFFF, 32'd1, 0, 0, 0, 32'h0, 0, 4'b0010);
        issue("R9 NV CMP", 4'hA, 1, 4'hF, 32'd3, 32'd5, 0, 0, 0, 32'h0, 0, 4'b0010);
    endtask

    task automatic test_idle();
        @(negedge clk);
        vld_i = 1'b0; opcode_i = 4'h4; set_st_i = 1'b1; cond_i = 4'hE;
        opa_i = 32'hFFFFFFFF; opb_i = 32'd1;
        #1;
        chk("R10 idle wr_en", {31'b0, wr_en_o}, 32'h0);
        @(posedge clk);
        #1;
        chk("R10 idle flags", {28'b0, flags_o}, 32'h2);
    endtask

    initial begin
        rst = 1'b1; vld_i = 1'b0; opcode_i = '0; set_st_i = 1'b0; cond_i = 4'hE;
        opa_i = '0; opb_i = '0; sh_carry_i = 1'b0; sh_nonzero_i = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        test_reset();
        test_arith();
        test_carry_in();
        test_logic();
        test_logic_flags();
        test_compare();
        test_conditions();
        test_idle();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_NS * 200000.0);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule